// File: doc/BRIEF.md
# Chip-Select Bus Cycle Timer

This block drives one asynchronous external bus with several chip-select regions. A host raises a request that names a region, a direction, an address and (for writes) a data word. The block turns that request into a timed bus cycle. The address is shown first. The region's chip enable then falls, followed by the read or write strobe. The strobe is released, the chip enable is held for a hold time, and the bus rests for a pause. The block then pulses an acknowledge back to the host.

Each region carries its own enable bit, a 2-bit clock-multiplier code and a packed timing word. All phase lengths of a cycle are counted in ticks, and one tick lasts the region's multiplier factor in base clocks. A region can let its strobe be stretched by an external ready line, which passes through a two-flop synchronizer. The region can then add a programmable number of ticks of strobe after ready returns. Read data is captured from the bus in the last clock of the strobe.

The timing word packs eight FW-bit fields, field i at bits [i*FW +: FW]: 0 address setup, 1 CE-to-strobe delay, 2 read strobe width, 3 write strobe width, 4 read hold, 5 write hold, 6 pause, 7 ready hold. The wait-mode flag sits in the top bit. Fields 0 to 6 hold the tick count minus one. Field 7 holds the plain tick count.

Top module: `bct_region_timer`

## Requirements
- R1: The multiplier code sets the tick length: code 0 gives 4 clocks, code 1 gives 1 clock, code 2 gives 2 clocks and code 3 gives 8 clocks. Every phase of a cycle lasts (field + 1) ticks.
- R2: Phases run in a fixed order, measured from the clock in which the request is first presented. CE falls after (setup + 1) ticks plus one clock. The strobe starts (delay + 1) ticks after CE falls. The strobe lasts (width + 1) ticks. CE rises (hold + 1) ticks after the strobe ends. The acknowledge comes (pause + 1) ticks after CE rises.
- R3: A read drives only the output-enable strobe and uses the read width and read hold fields. A write drives only the write-enable strobe, drives bus_dout with the request data while CE is low, and uses the write width and write hold fields.
- R4: After a read, rdata equals the bus_din value present in the last clock of the strobe. rdata keeps that value through later writes until the next read.
- R5: With wait mode set and tick length 1, ready low holds the strobe active past its programmed width. The strobe ends two clocks after the clock in which ready rises, because of the two-flop synchronizer, and then adds any ready-hold ticks.
- R6: With wait mode set, the strobe is lengthened by ready-hold ticks (field 7; 0 adds nothing) even when ready never goes low.
- R7: With wait mode clear, the level of ready has no effect on the strobe width.
- R8: A request to a region whose enable bit is clear causes no CE, no strobe and no acknowledge for as long as it is held.
- R9: The acknowledge is a single-clock pulse with CE and both strobes inactive. At most one CE is low at a time, and only the one for the requested region. bus_addr is stable while CE is low.
- R10: After reset all CE lines and both strobes are high, ack is low and rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside through a synchronizer |
| cfg_en | input | NREG | Per-region enable |
| cfg_mult | input | 2*NREG | Per-region multiplier code, region r at [2r+:2] |
| cfg_tim | input | TW*NREG | Per-region timing word, region r at [r*TW+:TW] |
| req | input | 1 | Host request, held until ack |
| req_we | input | 1 | 1 for write, 0 for read |
| req_sel | input | SELW | Region index |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | DW | Last captured read data |
| bus_addr | output | AW | External address |
| bus_dout | output | DW | External write data |
| bus_dout_oe | output | 1 | Write data drive enable |
| bus_din | input | DW | External read data |
| bus_ce_n | output | NREG | Active-low chip enables |
| bus_oe_n | output | 1 | Active-low output-enable strobe |
| bus_we_n | output | 1 | Active-low write-enable strobe |
| bus_ready | input | 1 | Asynchronous ready from the device |

## Verification
A wrong phase counter or divider value shows up at once as a phase of the wrong length on CE or a strobe, and the length is visible within the cycle in which it occurs. A state decode error gives overlapping strobes, two chip enables, or an acknowledge with CE still low, and these appear in the same clock. A wrong synchronizer depth or capture edge shifts the strobe end or the captured read word. Either error is seen at the acknowledge of that cycle.

// File: rtl/bct_pkg.sv
package bct_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_CEDLY,
    PH_STROBE,
    PH_WHOLD,
    PH_HOLD,
    PH_PAUSE
  } phase_e;

  localparam int NFIELD   = 8;
  localparam int F_SETUP  = 0;
  localparam int F_CEDLY  = 1;
  localparam int F_RDW    = 2;
  localparam int F_WRW    = 3;
  localparam int F_RDH    = 4;
  localparam int F_WRH    = 5;
  localparam int F_PAUSE  = 6;
  localparam int F_WHOLD  = 7;
  localparam int DIV_CW   = 3;

  function automatic logic [3:0] mult_factor(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd4;
      2'd1:    return 4'd1;
      2'd2:    return 4'd2;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/bct_sync2.sv
module bct_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/bct_tick_div.sv
module bct_tick_div
  import bct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] code,
  output logic       tick
);
  logic [DIV_CW-1:0] cnt_q, cnt_d;
  logic [3:0]        lim;

  assign lim  = mult_factor(code) - 4'd1;
  assign tick = (4'(cnt_q) == lim);

  always_comb begin
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bct_region_timer.sv
module bct_region_timer
  import bct_pkg::*;
#(
  parameter  int NREG = 2,
  parameter  int AW   = 16,
  parameter  int DW   = 16,
  parameter  int FW   = 4,
  localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int TW   = NFIELD * FW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG-1:0]   cfg_en,
  input  logic [2*NREG-1:0] cfg_mult,
  input  logic [TW*NREG-1:0] cfg_tim,
  input  logic              req,
  input  logic              req_we,
  input  logic [SELW-1:0]   req_sel,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              ack,
  output logic [DW-1:0]     rdata,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_dout_oe,
  input  logic [DW-1:0]     bus_din,
  output logic [NREG-1:0]   bus_ce_n,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  input  logic              bus_ready
);
  logic            rst_i_n;
  logic            rdy_s;
  logic            tick;
  logic            start;
  logic            expire;
  logic            sel_ok;
  int              sel_idx;
  logic [TW-1:0]   tim_sel;
  phase_e          phase_q, phase_d;
  logic [FW-1:0]   pcnt_q, pcnt_d;
  logic            ack_q, ack_d;
  logic [DW-1:0]   rdata_q, rdata_d;
  logic            we_q;
  logic [SELW-1:0] sel_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [TW-1:0]   tim_q;
  logic [1:0]      code_q;
  logic            ce_act, strb_act;

  bct_sync2 #(.RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_i_n));

  bct_sync2 #(.RST_VAL(1'b1)) u_rdy_sync (
    .clk(clk), .rst_n(rst_i_n), .d(bus_ready), .q(rdy_s));

  bct_tick_div u_div (
    .clk(clk), .rst_n(rst_i_n), .restart(start), .code(code_q), .tick(tick));

  assign sel_ok  = (int'(req_sel) < NREG);
  assign sel_idx = sel_ok ? int'(req_sel) : 0;
  assign tim_sel = cfg_tim[sel_idx*TW +: TW];
  assign expire  = tick && (pcnt_q == '0);

  // Field views of the latched timing word
  logic [FW-1:0] f_cedly, f_rdw, f_wrw, f_rdh, f_wrh, f_pause, f_whold;
  logic          f_wmode;
  assign f_cedly = tim_q[F_CEDLY*FW +: FW];
  assign f_rdw   = tim_q[F_RDW*FW +: FW];
  assign f_wrw   = tim_q[F_WRW*FW +: FW];
  assign f_rdh   = tim_q[F_RDH*FW +: FW];
  assign f_wrh   = tim_q[F_WRH*FW +: FW];
  assign f_pause = tim_q[F_PAUSE*FW +: FW];
  assign f_whold = tim_q[F_WHOLD*FW +: FW];
  assign f_wmode = tim_q[TW-1];

  always_comb begin
    phase_d = phase_q;
    pcnt_d  = pcnt_q;
    ack_d   = 1'b0;
    rdata_d = rdata_q;
    start   = 1'b0;
    if (tick && pcnt_q != '0) pcnt_d = pcnt_q - 1'b1;
    case (phase_q)
      PH_IDLE: begin
        if (req && sel_ok && cfg_en[sel_idx]) begin
          start   = 1'b1;
          phase_d = PH_SETUP;
          pcnt_d  = tim_sel[F_SETUP*FW +: FW];
        end
      end
      PH_SETUP: if (expire) begin
        phase_d = PH_CEDLY;
        pcnt_d  = f_cedly;
      end
      PH_CEDLY: if (expire) begin
        phase_d = PH_STROBE;
        pcnt_d  = we_q ? f_wrw : f_rdw;
      end
      PH_STROBE: if (expire) begin
        if (f_wmode && !rdy_s) begin
          phase_d = PH_STROBE;
        end else if (f_wmode && f_whold != '0) begin
          phase_d = PH_WHOLD;
          pcnt_d  = f_whold - 1'b1;
        end else begin
          phase_d = PH_HOLD;
          pcnt_d  = we_q ? f_wrh : f_rdh;
        end
      end
      PH_WHOLD: if (expire) begin
        phase_d = PH_HOLD;
        pcnt_d  = we_q ? f_wrh : f_rdh;
      end
      PH_HOLD: if (expire) begin
        phase_d = PH_PAUSE;
        pcnt_d  = f_pause;
      end
      PH_PAUSE: if (expire) begin
        phase_d = PH_IDLE;
        ack_d   = 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
    if (!we_q && (phase_q == PH_STROBE || phase_q == PH_WHOLD) && phase_d == PH_HOLD)
      rdata_d = bus_din;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      phase_q <= PH_IDLE;
      pcnt_q  <= '0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      phase_q <= phase_d;
      pcnt_q  <= pcnt_d;
      ack_q   <= ack_d;
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      we_q    <= 1'b0;
      sel_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      tim_q   <= '0;
      code_q  <= 2'd1;
    end else if (start) begin
      we_q    <= req_we;
      sel_q   <= req_sel;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      tim_q   <= tim_sel;
      code_q  <= cfg_mult[sel_idx*2 +: 2];
    end
  end

  assign ce_act   = (phase_q == PH_CEDLY) || (phase_q == PH_STROBE) ||
                    (phase_q == PH_WHOLD) || (phase_q == PH_HOLD);
  assign strb_act = (phase_q == PH_STROBE) || (phase_q == PH_WHOLD);

  for (genvar g = 0; g < NREG; g++) begin : g_ce
    assign bus_ce_n[g] = ~(ce_act && (int'(sel_q) == g));
  end

  assign bus_oe_n    = ~(strb_act && !we_q);
  assign bus_we_n    = ~(strb_act && we_q);
  assign bus_dout_oe = ce_act && we_q;
  assign bus_addr    = addr_q;
  assign bus_dout    = wdata_q;
  assign ack         = ack_q;
  assign rdata       = rdata_q;
endmodule

// File: rtl/bct_region_timer_chk.sv
module bct_region_timer_chk
  import bct_pkg::*;
#(
  parameter int NREG = 2,
  parameter int AW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREG-1:0] bus_ce_n,
  input logic            bus_oe_n,
  input logic            bus_we_n,
  input logic            ack,
  input logic [AW-1:0]   bus_addr,
  input phase_e          phase_q
);
  // R9
  one_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~bus_ce_n) <= 1);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_oe_n && !bus_we_n));

  // R2
  strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n || !bus_we_n) |-> (bus_ce_n != {NREG{1'b1}}));

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R2
  ack_after_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> ($past(phase_q) == PH_PAUSE));

  // R9
  ack_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (bus_ce_n == {NREG{1'b1}} && bus_oe_n && bus_we_n));

  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ce_n != {NREG{1'b1}} && $past(bus_ce_n != {NREG{1'b1}})) |-> $stable(bus_addr));
endmodule

bind bct_region_timer bct_region_timer_chk #(.NREG(NREG), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
  .bus_we_n(bus_we_n), .ack(ack), .bus_addr(bus_addr), .phase_q(phase_q));

// File: tb/bct_region_timer_test.sv
`timescale 1ns/1ps
module bct_region_timer_test;
  localparam int NREG = 2;
  localparam int AW   = 16;
  localparam int DW   = 16;
  localparam int FW   = 4;
  localparam int TW   = 8 * FW + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [NREG-1:0]    cfg_en;
  logic [2*NREG-1:0]  cfg_mult;
  logic [TW*NREG-1:0] cfg_tim;
  logic req, req_we;
  logic [0:0] req_sel;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic ack;
  logic [DW-1:0] rdata;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout;
  logic bus_dout_oe;
  logic [DW-1:0] bus_din;
  logic [NREG-1:0] bus_ce_n;
  logic bus_oe_n, bus_we_n, bus_ready;

  always #2 clk = ~clk;

  bct_region_timer #(.NREG(NREG), .AW(AW), .DW(DW), .FW(FW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mult(cfg_mult), .cfg_tim(cfg_tim),
    .req(req), .req_we(req_we), .req_sel(req_sel), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe), .bus_din(bus_din),
    .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_ready(bus_ready));

  int checks = 0;
  int errors = 0;

  typedef struct {
    int region; bit we; logic [AW-1:0] addr; logic [DW-1:0] wdata;
    int setup; int dly; int width; int hold; int pause;
  } exp_t;
  exp_t q[$];

  bit   en_c [NREG];
  int   code_c [NREG];
  int   fld_c [NREG][8];
  bit   wm_c [NREG];

  function automatic int fac(input int code);
    case (code)
      0: return 4;
      1: return 1;
      2: return 2;
      default: return 8;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic set_region(input int r, input bit en, input int code, input bit wm,
                            input int f0, input int f1, input int f2, input int f3,
                            input int f4, input int f5, input int f6, input int f7);
    en_c[r] = en; code_c[r] = code; wm_c[r] = wm;
    fld_c[r][0] = f0; fld_c[r][1] = f1; fld_c[r][2] = f2; fld_c[r][3] = f3;
    fld_c[r][4] = f4; fld_c[r][5] = f5; fld_c[r][6] = f6; fld_c[r][7] = f7;
    cfg_en[r] = en;
    cfg_mult[2*r +: 2] = 2'(code);
    for (int i = 0; i < 8; i++) cfg_tim[r*TW + i*FW +: FW] = FW'(fld_c[r][i]);
    cfg_tim[r*TW + TW - 1] = wm;
  endtask

  // Driver: pushes the expected cycle shape, runs the handshake.
  task automatic xfer(input int r, input bit w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input int k);
    exp_t e;
    int f;
    int sc;
    bit got;
    f = fac(code_c[r]);
    e.region = r; e.we = w; e.addr = a; e.wdata = d;
    e.setup = (fld_c[r][0] + 1) * f + 1;
    e.dly   = (fld_c[r][1] + 1) * f;
    e.width = ((w ? fld_c[r][3] : fld_c[r][2]) + 1) * f + (wm_c[r] ? fld_c[r][7] * f : 0);
    if (k >= 0) e.width = k + 2 + fld_c[r][7];
    e.hold  = ((w ? fld_c[r][5] : fld_c[r][4]) + 1) * f;
    e.pause = (fld_c[r][6] + 1) * f;
    q.push_back(e);
    if (k >= 0) bus_ready = 1'b0;
    @(negedge clk);
    req_sel = 1'(r); req_we = w; req_addr = a; req_wdata = d; req = 1'b1;
    sc = 0; got = 1'b0;
    while (!got) begin
      @(negedge clk); #1;
      if (k >= 0 && (!bus_oe_n || !bus_we_n)) begin
        sc++;
        if (sc == k) bus_ready = 1'b1;
      end
      if (ack) got = 1'b1;
    end
    req = 1'b0;
    if (k >= 0) bus_ready = 1'b1;
  endtask

  // Changing read data every clock exposes the capture point.
  initial begin
    bus_din = 16'h5A00;
    forever begin
      @(negedge clk);
      bus_din = bus_din + 16'h0113;
    end
  end

  // Monitor: measures phases at the pins and compares with the queue.
  initial begin : monitor
    int st, cs, cd, cw, ch, cp, reg_seen;
    logic [DW-1:0] last_din, last_read;
    logic [AW-1:0] addr_seen;
    logic [DW-1:0] dout_seen;
    bit dout_oe_seen;
    exp_t e;
    st = 0; cs = 0; cd = 0; cw = 0; ch = 0; cp = 0; reg_seen = 0;
    last_din = '0; last_read = '0; addr_seen = '0; dout_seen = '0; dout_oe_seen = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        case (st)
          0: begin
            if (ack) chk(1'b0, "R9", "ack outside a cycle", 1, 0);
            if (req && bus_ce_n == '1) begin cs = 1; st = 1; end
          end
          1: begin
            if (!req) st = 0;
            else if (bus_ce_n == '1) cs++;
            else begin
              cd = 1; st = 2;
              reg_seen = bus_ce_n[0] ? 1 : 0;
              if (bus_ce_n == 2'b00) chk(1'b0, "R9", "two CE low", 0, 1);
            end
          end
          2: begin
            if (!bus_oe_n || !bus_we_n) begin
              cw = 1; st = 3; last_din = bus_din;
              addr_seen = bus_addr; dout_seen = bus_dout; dout_oe_seen = bus_dout_oe;
              e = q[0];
              chk(e.we ? (!bus_we_n && bus_oe_n) : (!bus_oe_n && bus_we_n), "R3",
                  "strobe matches direction", int'(bus_we_n), int'(!e.we));
            end else cd++;
          end
          3: begin
            if (!bus_oe_n || !bus_we_n) begin cw++; last_din = bus_din; end
            else begin ch = 1; st = 4; end
          end
          4: begin
            if (bus_ce_n != '1) ch++;
            else begin cp = 1; st = 5; end
          end
          default: begin
            if (ack) begin
              if (q.size() == 0) chk(1'b0, "R9", "ack with no request", 1, 0);
              else begin
                e = q.pop_front();
                chk(reg_seen == e.region, "R9", "region CE", reg_seen, e.region);
                chk(cs == e.setup, "R2", "request to CE low", cs, e.setup);
                chk(cd == e.dly, "R2", "CE to strobe", cd, e.dly);
                chk(cw == e.width, "R1", "strobe width", cw, e.width);
                chk(ch == e.hold, "R2", "hold", ch, e.hold);
                chk(cp == e.pause, "R2", "pause", cp, e.pause);
                chk(addr_seen == e.addr, "R9", "bus address", int'(addr_seen), int'(e.addr));
                if (e.we) begin
                  chk(dout_oe_seen && dout_seen == e.wdata, "R3", "write data",
                      int'(dout_seen), int'(e.wdata));
                  chk(rdata == last_read, "R4", "rdata held over write",
                      int'(rdata), int'(last_read));
                end else begin
                  last_read = last_din;
                  chk(rdata == last_din, "R4", "read capture", int'(rdata), int'(last_din));
                end
              end
              st = 0;
            end else cp++;
          end
        endcase
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual 0 expected 1");
    finish_run();
  end

  initial begin : stim
    bit quiet;
    rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_sel = '0; req_addr = '0; req_wdata = '0;
    bus_ready = 1'b1; cfg_en = '0; cfg_mult = '0; cfg_tim = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R10
    chk(bus_ce_n == '1 && bus_oe_n && bus_we_n, "R10", "bus idle after reset",
        int'({bus_ce_n, bus_oe_n, bus_we_n}), 15);
    chk(!ack && rdata == '0, "R10", "ack and rdata after reset", int'(rdata), 0);

    set_region(0, 1, 1, 0, 2, 1, 3, 1, 1, 2, 2, 0);
    set_region(1, 1, 2, 0, 1, 0, 2, 4, 0, 1, 1, 0);
    xfer(0, 0, 16'h1234, 16'h0000, -1);   // R1 R3 code 1 read
    xfer(0, 1, 16'h2345, 16'hBEEF, -1);   // R3 write fields
    xfer(1, 1, 16'h3456, 16'hCAFE, -1);   // R1 code 2
    xfer(1, 0, 16'h4567, 16'h0000, -1);
    set_region(0, 1, 0, 0, 1, 0, 1, 2, 0, 1, 0, 0);
    xfer(0, 0, 16'h5678, 16'h0000, -1);   // R1 code 0
    set_region(0, 1, 3, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    xfer(0, 1, 16'h6789, 16'h1357, -1);   // R1 code 3
    set_region(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    xfer(0, 0, 16'h789A, 16'h0000, -1);   // all-zero fields
    xfer(0, 1, 16'h89AB, 16'h2468, -1);

    // R8: disabled region
    set_region(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    req_sel = 1'b1; req_we = 1'b0; req_addr = 16'h0F0F; req = 1'b1;
    quiet = 1'b1;
    repeat (30) begin
      @(negedge clk); #1;
      if (bus_ce_n != '1 || !bus_oe_n || !bus_we_n || ack) quiet = 1'b0;
    end
    chk(quiet, "R8", "disabled region stays silent", int'(quiet), 1);
    req = 1'b0;
    @(negedge clk);

    // R5: ready stretches the strobe
    set_region(0, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    xfer(0, 0, 16'h1111, 16'h0000, 5);
    // R5 R6: stretch then ready-hold ticks
    set_region(0, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 2);
    xfer(0, 1, 16'h2222, 16'h3333, 4);
    // R6: ready-hold ticks with ready always high
    set_region(0, 1, 2, 1, 0, 0, 1, 1, 0, 0, 0, 3);
    xfer(0, 0, 16'h4444, 16'h0000, -1);
    // R7: wait mode off, ready low ignored
    set_region(0, 1, 1, 0, 1, 0, 2, 0, 0, 0, 0, 3);
    bus_ready = 1'b0;
    xfer(0, 0, 16'h5555, 16'h0000, -1);
    bus_ready = 1'b1;

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R9", "all cycles acknowledged", q.size(), 0);
    finish_run();
  end
endmodule